// File: doc/BRIEF.md
# Byte-Window BCD Calendar Clock

This block is a real-time clock and calendar that a host reaches through the eight highest byte addresses of a byte-wide address space. Seven live counters hold seconds, minutes, hours, day of week, day of month, month and two-digit year, all in packed BCD with a 24-hour clock. They advance once for each pulse on a one-per-second strobe. A full rollover, from seconds up to the year, settles within that single clock edge. Month lengths of 28, 29, 30 and 31 days are applied automatically. By default a year whose value is a multiple of four is a leap year.

The host never touches the live counters directly. It sees a bank of holding bytes that the block refreshes from the counters once per second. A control byte at the lowest window address gates this path. Setting its load bit opens the holding bytes for host writes. Clearing the load bit copies the holding bytes into the counters. Setting its freeze bit stops the refresh, so a multi-byte read sees one consistent time, while counting continues underneath. The low six bits of the control byte store a signed calibration value. The host can read it back, and it has no effect on timekeeping here.

Reads are combinational, like an asynchronous SRAM. Any address outside the window reads as zero, and a write to such an address changes nothing.

Top module: `bcd_cal_window`

## Requirements
- R1: The window is the eight addresses whose bits [14:3] are all ones, so offsets 0 to 7 sit at 7FF8h to 7FFFh. The offsets hold, in this order: control, seconds, minutes, hours, day of week, date, month and year. Reads outside the window return 00h, and writes outside it have no effect.
- R2: After reset, the control byte is 00h, the time is 00:00:00, the day of week is 01, the date is 01, the month is 01 and the year is 00. The live counters and the holding bytes both take these values.
- R3: A `sec_tick` pulse sampled at clock edge N advances the live counters at edge N. The holding bytes show the new time from edge N+1, provided that refresh is allowed then.
- R4: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. The day of week runs 1 to 7 and then back to 1, and the year wraps from 99 to 00. All carries ripple within one tick, so 23:59:59 on 31/12/99 becomes 00:00:00 on 01/01/00.
- R5: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other 30- or 31-day months. February ends at 28, or at 29 when the year is a multiple of four (year 00 counts as one). A wrap of the date increments the month.
- R6: Control bit 7 is the load bit. Writes to offsets 1 to 7 take effect only while it is set, and are ignored while it is clear. While it is set, the once-per-second refresh does not change the holding bytes.
- R7: A control write that clears a set load bit copies offsets 1 to 7 into the live counters at that edge. A tick sampled at the same edge is dropped.
- R8: Control bit 6 is the freeze bit. While it is set, the holding bytes keep their value across ticks, and the live counters keep counting. The first refresh after the bit clears shows the full elapsed count.
- R9: Control bits 5:0 (bit 5 the sign, bits 4:0 the magnitude) are stored as written and read back unchanged. The control byte changes only by a host write and is never refreshed.
- R10: Bits with no meaning in a field are stored as zero and read as zero. These are bit 7 of seconds and minutes, bits 7:6 of hours and date, bits 7:3 of the day of week, and bits 7:5 of the month.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| bus_addr | input | 15 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |

## Verification
The bench sets the time to each month-end and year-end boundary and checks the calendar after one tick. It covers 31 December of year 99, February in a leap year, in a common year and in year 00, and the 30-day months. A design with a wrong month table or leap test would show a date of 29, 30, 31 or 32 instead of 01.

It also checks the holding bytes in the idle cycle straight after a tick, where a design that skips the extra refresh cycle would show the new time one edge too early.

It drives a tick in the same cycle that the load bit is cleared. A design that lets the tick win ends one second ahead.

It sets the freeze bit across several ticks and checks the seconds byte after the bit clears. A design that pauses counting while frozen would come back late.

Random traffic mixes ticks, control writes, writes that must be ignored, and reads inside and outside the window. All of it is checked against a bench model that counts in binary.

// File: rtl/cal_pkg.sv
`timescale 1ns/100ps
package cal_pkg;
   localparam int unsigned SLOTS  = 8;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   // window offsets
   localparam int IX_CTRL  = 0;
   localparam int IX_SEC   = 1;
   localparam int IX_MIN   = 2;
   localparam int IX_HOUR  = 3;
   localparam int IX_WDAY  = 4;
   localparam int IX_MDAY  = 5;
   localparam int IX_MONTH = 6;
   localparam int IX_YEAR  = 7;

   // control byte bits
   localparam int CB_LOAD   = 7;
   localparam int CB_FREEZE = 6;

   function automatic byte_t slot_mask(int s);
      case (s)
         IX_SEC, IX_MIN:   return 8'h7F;
         IX_HOUR, IX_MDAY: return 8'h3F;
         IX_WDAY:          return 8'h07;
         IX_MONTH:         return 8'h1F;
         default:          return 8'hFF;
      endcase
   endfunction

   function automatic byte_t slot_low(int s);
      case (s)
         IX_WDAY, IX_MDAY, IX_MONTH: return 8'h01;
         default:                    return 8'h00;
      endcase
   endfunction

   // static upper bound; the date bound is replaced at run time
   function automatic byte_t slot_top(int s);
      case (s)
         IX_SEC, IX_MIN: return 8'h59;
         IX_HOUR:        return 8'h23;
         IX_WDAY:        return 8'h07;
         IX_MDAY:        return 8'h31;
         IX_MONTH:       return 8'h12;
         IX_YEAR:        return 8'h99;
         default:        return 8'h00;
      endcase
   endfunction

   function automatic byte_t bcd_step(byte_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   function automatic logic four_year_leap(byte_t yr);
      int n;
      n = int'(yr[7:4]) * 10 + int'(yr[3:0]);
      return (n % 4) == 0;
   endfunction

   function automatic byte_t month_days(byte_t mon, logic leap);
      case (mon)
         8'h02:                     return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                   return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/cal_bcd_counter.sv
`timescale 1ns/100ps
module cal_bcd_counter
   import cal_pkg::*;
#(
   parameter byte_t LOW = 8'h00,
   parameter byte_t RST = 8'h00
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  step,
   input  logic  load,
   input  byte_t load_val,
   input  byte_t top_val,
   output byte_t value,
   output logic  at_top
);
   if (LOW[3:0] > 4'd9 || RST[3:0] > 4'd9) begin : g_bad_digit
      $error("cal_bcd_counter: LOW and RST must be BCD");
   end

   // at or beyond the bound: next step wraps (also clears out-of-range loads)
   assign at_top = (value >= top_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     value <= RST;
      else if (load)  value <= load_val;
      else if (step)  value <= at_top ? LOW : bcd_step(value);
   end
endmodule

// File: rtl/cal_window_bank.sv
`timescale 1ns/100ps
module cal_window_bank
   import cal_pkg::*;
#(
   parameter int    ADDR_W     = 15,
   parameter byte_t RESET_YEAR = 8'h00
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  byte_t                    wdata,
   input  logic                     wr_en,
   input  logic                     refresh,
   input  byte_t [SLOTS-1:1]        live,
   output byte_t [SLOTS-1:0]        hold,
   output logic                     load_pulse,
   output byte_t                    rdata
);
   localparam int IDX_W = $clog2(SLOTS);

   logic             in_win;
   logic [IDX_W-1:0] idx;
   logic [SLOTS-1:0] slot_wr;
   logic             wr_open;
   logic             frozen;

   assign in_win  = &addr[ADDR_W-1:IDX_W];
   assign idx     = addr[IDX_W-1:0];
   assign wr_open = hold[IX_CTRL][CB_LOAD];
   assign frozen  = hold[IX_CTRL][CB_FREEZE];

   always_comb begin
      for (int s = 0; s < SLOTS; s++) begin
         slot_wr[s] = wr_en && in_win && (idx == IDX_W'(s));
      end
   end

   assign load_pulse = slot_wr[IX_CTRL] && wr_open && !wdata[CB_LOAD];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      byte_t r_q;
      assign hold[s] = r_q;
      if (s == IX_CTRL) begin : g_ctrl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          r_q <= '0;
            else if (slot_wr[s]) r_q <= wdata;
         end
      end else begin : g_time
         localparam byte_t RV = (s == IX_YEAR) ? RESET_YEAR : slot_low(s);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             r_q <= RV;
            else if (slot_wr[s] && wr_open)         r_q <= wdata & slot_mask(s);
            else if (refresh && !wr_open && !frozen) r_q <= live[s];
         end
      end
   end

   assign rdata = in_win ? hold[idx] : '0;
endmodule

// File: rtl/bcd_cal_window.sv
`timescale 1ns/100ps
module bcd_cal_window
   import cal_pkg::*;
#(
   parameter int    ADDR_W     = 15,
   parameter bit    LEAP_RULE  = 1'b1,
   parameter byte_t RESET_YEAR = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_we,
   output logic [7:0]        bus_rdata
);
   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr
      $error("bcd_cal_window: ADDR_W out of range");
   end
   if (RESET_YEAR[3:0] > 4'd9 || RESET_YEAR[7:4] > 4'd9) begin : g_bad_year
      $error("bcd_cal_window: RESET_YEAR must be BCD");
   end

   byte_t [SLOTS-1:0] hold;
   byte_t [SLOTS-1:1] live;
   byte_t [SLOTS-1:1] top_val;
   logic  [SLOTS-1:1] at_top;
   logic  [SLOTS-1:1] step;
   logic              load_pulse;
   logic              tick_q;
   logic              leap;
   logic              adv, s_min, s_hour, s_day, s_mon, s_year;
   logic              unused_tops;

   // refresh of holding bytes trails the counter update by one edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_q <= 1'b0;
      else        tick_q <= sec_tick;
   end

   if (LEAP_RULE) begin : g_leap4
      assign leap = four_year_leap(live[IX_YEAR]);
   end else begin : g_noleap
      assign leap = 1'b0;
   end

   always_comb begin
      for (int s = 1; s < SLOTS; s++) top_val[s] = slot_top(s);
      top_val[IX_MDAY] = month_days(live[IX_MONTH], leap);
   end

   // carry chain: load wins over a coincident tick
   assign adv    = sec_tick && !load_pulse;
   assign s_min  = adv    && at_top[IX_SEC];
   assign s_hour = s_min  && at_top[IX_MIN];
   assign s_day  = s_hour && at_top[IX_HOUR];
   assign s_mon  = s_day  && at_top[IX_MDAY];
   assign s_year = s_mon  && at_top[IX_MONTH];
   assign step   = {s_year, s_mon, s_day, s_day, s_hour, s_min, adv};
   assign unused_tops = at_top[IX_WDAY] ^ at_top[IX_YEAR];

   for (genvar s = 1; s < SLOTS; s++) begin : g_cnt
      localparam byte_t RV = (s == IX_YEAR) ? RESET_YEAR : slot_low(s);
      cal_bcd_counter #(
         .LOW (slot_low(s)),
         .RST (RV)
      ) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .step     (step[s]),
         .load     (load_pulse),
         .load_val (hold[s]),
         .top_val  (top_val[s]),
         .value    (live[s]),
         .at_top   (at_top[s])
      );
   end

   cal_window_bank #(
      .ADDR_W     (ADDR_W),
      .RESET_YEAR (RESET_YEAR)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .wr_en      (bus_we),
      .refresh    (tick_q),
      .live       (live),
      .hold       (hold),
      .load_pulse (load_pulse),
      .rdata      (bus_rdata)
   );
endmodule

// File: rtl/cal_window_chk.sv
`timescale 1ns/100ps
module cal_window_chk
   import cal_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_tick,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [7:0]        bus_rdata,
   input logic              tick_q,
   input logic              load_pulse,
   input byte_t [SLOTS-1:0] hold,
   input byte_t [SLOTS-1:1] live
);
   logic in_win;
   assign in_win = &bus_addr[ADDR_W-1:3];

   AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |-> bus_rdata == 8'h00);                                   // R1
   AST_SEC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && bus_addr[2:0] == 3'd1) |-> !bus_rdata[7]);             // R10
   AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !load_pulse) |=> $stable(live));                    // R3
   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !load_pulse && live[1] == 8'h59) |=> live[1] == 8'h00); // R4
   AST_WRITE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold[0][7] && !tick_q) |=> $stable(hold[7:1]));                 // R6
   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |=> live == $past(hold[7:1]));                         // R7
   AST_READ_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold[0][6] && !bus_we) |=> $stable(hold[7:1]));                  // R8
   AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(hold[0]));                                    // R9
endmodule

bind bcd_cal_window cal_window_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sec_tick   (sec_tick),
   .bus_addr   (bus_addr),
   .bus_we     (bus_we),
   .bus_rdata  (bus_rdata),
   .tick_q     (tick_q),
   .load_pulse (load_pulse),
   .hold       (hold),
   .live       (live)
);

// File: tb/tb_bcd_cal_window.sv
`timescale 1ns/100ps
module tb_bcd_cal_window;
   import cal_pkg::*;
   localparam int AW = 15;
   localparam logic [AW-1:0] WIN = 15'h7FF8;

   logic          clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   bcd_cal_window dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata)
   );

   always #2.5 clk = ~clk;

   // ---------------- reference model (binary arithmetic) ----------------
   byte_t m_hold [8];
   byte_t m_live [8];
   byte_t nh [8];
   bit    m_tq, mwin, mld;
   int    mix;

   function automatic int b2i(byte_t v); return int'(v[7:4]) * 10 + int'(v[3:0]); endfunction
   function automatic byte_t i2b(int n); return byte_t'((n / 10) * 16 + (n % 10)); endfunction
   function automatic int mlen(int mo, int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction
   function automatic byte_t fmask(int ix);
      byte_t t [8] = '{8'hFF, 8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
      return t[ix];
   endfunction

   task automatic model_advance();
      int s, mi, h, wd, dt, mo, yr;
      s = b2i(m_live[1]) + 1;
      if (s < 60) begin m_live[1] = i2b(s); return; end
      m_live[1] = 0; mi = b2i(m_live[2]) + 1;
      if (mi < 60) begin m_live[2] = i2b(mi); return; end
      m_live[2] = 0; h = b2i(m_live[3]) + 1;
      if (h < 24) begin m_live[3] = i2b(h); return; end
      m_live[3] = 0;
      wd = b2i(m_live[4]); m_live[4] = i2b(wd == 7 ? 1 : wd + 1);
      dt = b2i(m_live[5]) + 1; mo = b2i(m_live[6]); yr = b2i(m_live[7]);
      if (dt <= mlen(mo, yr)) begin m_live[5] = i2b(dt); return; end
      m_live[5] = 8'h01; mo++;
      if (mo <= 12) begin m_live[6] = i2b(mo); return; end
      m_live[6] = 8'h01; m_live[7] = i2b((yr + 1) % 100);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hold = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
         m_live = m_hold;
         m_tq   = 1'b0;
      end else begin
         mwin = &bus_addr[AW-1:3];
         mix  = int'(bus_addr[2:0]);
         mld  = bus_we && mwin && mix == 0 && m_hold[0][7] && !bus_wdata[7];
         nh   = m_hold;
         if (m_tq && !m_hold[0][7] && !m_hold[0][6])
            for (int i = 1; i < 8; i++) nh[i] = m_live[i];
         if (bus_we && mwin) begin
            if (mix == 0) nh[0] = bus_wdata;
            else if (m_hold[0][7]) nh[mix] = bus_wdata & fmask(mix);
         end
         if (mld) for (int i = 1; i < 8; i++) m_live[i] = m_hold[i];
         else if (sec_tick) model_advance();
         m_hold = nh;
         m_tq   = sec_tick;
      end
   end

   function automatic byte_t model_read(logic [AW-1:0] a);
      return (&a[AW-1:3]) ? m_hold[a[2:0]] : 8'h00;
   endfunction

   // ---------------- stimulus and checking ----------------
   task automatic drive(bit t, bit w, logic [AW-1:0] a, byte_t d);
      @(negedge clk);
      sec_tick = t; bus_we = w; bus_addr = a; bus_wdata = d;
      #1;
   endtask

   task automatic check(string req, string what, byte_t got, byte_t exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
      end
   endtask

   task automatic rd_lit(int ix, byte_t exp, string req);
      drive(1'b0, 1'b0, WIN | AW'(ix), 8'h00);
      check(req, $sformatf("slot %0d", ix), bus_rdata, exp);
   endtask

   task automatic rd_model(logic [AW-1:0] a, bit t, string req);
      drive(t, 1'b0, a, 8'h00);
      check(req, $sformatf("addr %04h", a), bus_rdata, model_read(a));
   endtask

   task automatic wr(int ix, byte_t d);
      drive(1'b0, 1'b1, WIN | AW'(ix), d);
   endtask

   task automatic tick_settle();
      drive(1'b1, 1'b0, 15'h0000, 8'h00);
      drive(1'b0, 1'b0, 15'h0000, 8'h00);
   endtask

   task automatic set_time(byte_t s, byte_t mi, byte_t h, byte_t wd, byte_t dt, byte_t mo, byte_t yr);
      wr(0, 8'h80);
      wr(1, s); wr(2, mi); wr(3, h); wr(4, wd); wr(5, dt); wr(6, mo); wr(7, yr);
      wr(0, 8'h00);
   endtask

   task automatic expect_date(byte_t dt, byte_t mo, byte_t yr, string req);
      rd_lit(5, dt, req); rd_lit(6, mo, req); rd_lit(7, yr, req);
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R3 watchdog: got timeout expected completion");
         report();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset image, R1 outside read
      rd_lit(0, 8'h00, "R2"); rd_lit(1, 8'h00, "R2"); rd_lit(2, 8'h00, "R2");
      rd_lit(3, 8'h00, "R2"); rd_lit(4, 8'h01, "R2"); rd_lit(5, 8'h01, "R2");
      rd_lit(6, 8'h01, "R2"); rd_lit(7, 8'h00, "R2");
      rd_model(15'h0123, 1'b0, "R1");

      // R9 calibration readback, R3 refresh latency
      wr(0, 8'h2B);
      rd_lit(0, 8'h2B, "R9");
      drive(1'b1, 1'b0, 15'h0000, 8'h00);
      rd_lit(1, 8'h00, "R3");          // counters moved, holding not yet
      rd_lit(1, 8'h01, "R3");
      rd_lit(0, 8'h2B, "R9");
      wr(0, 8'h00);

      // R4 full cascade at year end
      set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
      tick_settle();
      rd_lit(1, 8'h00, "R4"); rd_lit(2, 8'h00, "R4"); rd_lit(3, 8'h00, "R4");
      rd_lit(4, 8'h01, "R4");
      expect_date(8'h01, 8'h01, 8'h00, "R4");

      // R5 month lengths and leap years
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
      tick_settle(); expect_date(8'h29, 8'h02, 8'h24, "R5");
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
      tick_settle(); expect_date(8'h01, 8'h03, 8'h24, "R5");
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
      tick_settle(); expect_date(8'h01, 8'h03, 8'h23, "R5");
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00);
      tick_settle(); expect_date(8'h29, 8'h02, 8'h00, "R5");
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h07);
      tick_settle(); expect_date(8'h01, 8'h05, 8'h07, "R5");
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h11, 8'h07);
      tick_settle(); expect_date(8'h01, 8'h12, 8'h07, "R5");
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h08, 8'h07);
      tick_settle(); expect_date(8'h31, 8'h08, 8'h07, "R5");

      // R10 unused bits
      wr(0, 8'h80);
      for (int i = 1; i < 8; i++) wr(i, 8'hFF);
      rd_lit(1, 8'h7F, "R10"); rd_lit(2, 8'h7F, "R10"); rd_lit(3, 8'h3F, "R10");
      rd_lit(4, 8'h07, "R10"); rd_lit(5, 8'h3F, "R10"); rd_lit(6, 8'h1F, "R10");

      // R6 writes ignored when load bit clear; refresh held while set
      set_time(8'h20, 8'h10, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30);
      wr(1, 8'h33);
      rd_lit(1, 8'h20, "R6");
      drive(1'b0, 1'b1, 15'h1238, 8'h55);          // R1 outside write
      rd_lit(0, 8'h00, "R1"); rd_lit(1, 8'h20, "R1");
      wr(0, 8'h80);
      tick_settle();
      rd_lit(1, 8'h20, "R6");

      // R7 load beats a coincident tick
      wr(1, 8'h40);
      drive(1'b1, 1'b1, WIN, 8'h00);
      tick_settle();
      rd_lit(1, 8'h41, "R7");

      // R8 freeze, counting continues
      set_time(8'h10, 8'h00, 8'h12, 8'h04, 8'h10, 8'h10, 8'h10);
      wr(0, 8'h40);
      for (int i = 0; i < 3; i++) tick_settle();
      rd_lit(1, 8'h10, "R8");
      wr(0, 8'h00);
      tick_settle();
      rd_lit(1, 8'h14, "R8");

      // random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         bit t;
         int op;
         t  = ($urandom % 3) == 0;
         op = $urandom % 16;
         if (n % 700 == 0)
            set_time(i2b($urandom % 60), i2b($urandom % 60), i2b($urandom % 24),
                     i2b(1 + $urandom % 7), i2b(1 + $urandom % 28),
                     i2b(1 + $urandom % 12), i2b($urandom % 100));
         else if (op == 0)
            drive(t, 1'b1, WIN, byte_t'($urandom) & 8'h7F);
         else if (op == 1)
            drive(t, 1'b1, WIN | AW'(1 + $urandom % 7), byte_t'($urandom));
         else if (op == 2)
            drive(t, 1'b1, AW'($urandom) & 15'h7FF7, byte_t'($urandom));
         else if (op == 3)
            rd_model(AW'($urandom) & 15'h7FF7, t, "R1");
         else
            rd_model(WIN | AW'($urandom % 8), t, "R3");
      end

      done = 1'b1;
      report();
      $finish;
   end
endmodule